// File: doc/BRIEF.md
# Permutation-Coded Replacement Selector

This block keeps the replacement field of one cache index in a 2, 3 or 4 way set-associative cache and names the way a fill should overwrite. The recency order of the ways is held as one dense code. Each permutation of the ways gets its lexicographic rank, so four ways need only five bits. The leftmost way in the decoded order is the stalest and the rightmost is the freshest. A hit or a fill moves the touched way to the fresh end, and the other ways keep their relative order.

The cache pipeline reads the field stored beside the tag and presents it on the load port. The block works from that value in the same cycle and returns the updated field for write-back. The field is also held internally, so a run of operations on one index needs no reload. Four policies are selectable: true recency, replacement order (only fills reorder), pseudo-random from a free-running LFSR, and direct (the caller names the way). In every policy, locked ways are skipped.

Top module: `perm_lru_sel`

## Requirements
- R1: After reset the stored code is 0, which is the identity order (way 0 stalest). With no locks in recency mode the victim is way 0 and fill_block is low.
- R2: The code is the lexicographic rank of the order read from stalest to freshest. It is 5 bits wide for 4 ways, 3 bits for 3 ways and 1 bit for 2 ways. For 4 ways, 0 is 0123, 2 is 0213, 3 is 0231, 9 is 1230 and 23 is 3210.
- R3: In recency mode (repl_mode 0), an access to a way moves that way to the freshest end and keeps the order of the others. The new code appears on state_q one clock later, and on state_nxt in the same cycle.
- R4: A fill that is not blocked moves the victim way to the freshest end, in every mode.
- R5: In recency mode (0) and replacement-order mode (1), the victim is the first unlocked way counted from the stalest end.
- R6: When every candidate way is locked, fill_block is high and a fill leaves the code unchanged.
- R7: In every mode other than recency, accesses leave the code unchanged.
- R8: In random mode (repl_mode 2), the victim is an unlocked way in range. It comes from an LFSR value reduced modulo the way count, stepping upward past locked ways.
- R9: In direct mode (repl_mode 3), the victim is acc_way. fill_block rises if that way is locked.
- R10: When a fill that is not blocked and an access arrive in the same cycle, the fill's victim is moved and the access is dropped.
- R11: While ld_en is high, ld_code replaces the stored code as the base for that cycle. An out-of-range code decodes as the identity order. It is kept unchanged if no update occurs, and it is replaced by a legal code on any update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access (hit) strobe |
| acc_way | input | WW | Accessed way; also the target in direct mode |
| fill_req | input | 1 | Fill request: replace the victim way |
| repl_mode | input | 2 | 0 recency, 1 replacement order, 2 random, 3 direct |
| way_lock | input | WAYS | Per-way lock; a locked way is never a victim |
| ld_en | input | 1 | Use ld_code as this cycle's base field |
| ld_code | input | SW | Field read from the tag array |
| victim_way | output | WW | Way chosen for the fill |
| fill_block | output | 1 | No way may be replaced |
| state_q | output | SW | Stored replacement code |
| state_nxt | output | SW | Code to write back this cycle |

## Verification
An access and a fill can arrive in the same clock, and a load can coincide with either of them. The bench drives acc_en and fill_req together with different target ways. It then checks that only the victim reaches the freshest end and that the accessed way stays where it was. It also loads a code and accesses in the same cycle, including out-of-range codes, and checks the result against a list model of the order. That model is compared with state_q and state_nxt on every clock, both in directed steps and in a long random run.

// File: rtl/rp_pkg.sv
package rp_pkg;

   localparam int MAXW = 4;

   typedef logic [1:0]           way_t;
   typedef way_t [MAXW-1:0]      order_t;   // [0] stalest
   typedef logic [4:0]           code_t;

   typedef enum logic [1:0] {
      MODE_LRU    = 2'd0,
      MODE_LRR    = 2'd1,
      MODE_RAND   = 2'd2,
      MODE_DIRECT = 2'd3
   } repl_mode_e;

   function automatic int fact(input int n);
      int r;
      r = 1;
      for (int i = 2; i <= MAXW; i++) if (i <= n) r = r * i;
      return r;
   endfunction

   function automatic int code_bits(input int n);
      return (n >= 4) ? 5 : (n == 3) ? 3 : 1;
   endfunction

   function automatic order_t ident_order();
      order_t o;
      for (int i = 0; i < MAXW; i++) o[i] = way_t'(i);
      return o;
   endfunction

   // rank -> order, out-of-range rank gives identity
   function automatic order_t decode_order(input code_t code, input int n);
      order_t avail, p;
      int     rank, f, d;
      avail = ident_order();
      p     = ident_order();
      rank  = int'(code);
      if (rank >= fact(n)) rank = 0;
      for (int i = 0; i < MAXW; i++) begin
         if (i < n) begin
            f = fact(n - 1 - i);
            d = 0;
            for (int k = 0; k < MAXW - 1; k++) begin
               if (k < n - 1 - i && rank >= f) begin
                  rank = rank - f;
                  d    = d + 1;
               end
            end
            p[i] = avail[d];
            for (int j = 0; j < MAXW - 1; j++)
               if (j >= d) avail[j] = avail[j+1];
         end
      end
      return p;
   endfunction

   function automatic code_t encode_order(input order_t p, input int n);
      int rank, d;
      rank = 0;
      for (int i = 0; i < MAXW; i++) begin
         if (i < n) begin
            d = 0;
            for (int j = 0; j < MAXW; j++)
               if (j > i && j < n && p[j] < p[i]) d = d + 1;
            rank = rank + d * fact(n - 1 - i);
         end
      end
      return code_t'(rank);
   endfunction

   function automatic order_t move_to_fresh(input order_t p, input way_t w, input int n);
      order_t o;
      int     k;
      o = p;
      k = 0;
      for (int i = 0; i < MAXW; i++) begin
         if (i < n && p[i] != w) begin
            o[k] = p[i];
            k = k + 1;
         end
      end
      o[n-1] = w;
      return o;
   endfunction

endpackage

// File: rtl/rp_lfsr.sv
module rp_lfsr #(
   parameter int          W    = 8,
   parameter logic [W-1:0] TAPS = 8'hB8
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] value
);
   logic [W-1:0] lfsr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lfsr_q <= {{(W-1){1'b0}}, 1'b1};
      else if (lfsr_q[0]) lfsr_q <= (lfsr_q >> 1) ^ TAPS;
      else lfsr_q <= lfsr_q >> 1;
   end

   assign value = lfsr_q;

   a_r8_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);
endmodule

// File: rtl/rp_victim_pick.sv
module rp_victim_pick
   import rp_pkg::*;
#(
   parameter int WAYS   = 4,
   parameter int LFSR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  repl_mode_e        mode,
   input  order_t            order,
   input  logic [WAYS-1:0]   lock,
   input  way_t              dir_way,
   input  logic [LFSR_W-1:0] rnd,
   output way_t              victim,
   output logic              blocked
);
   logic [MAXW-1:0] lk;
   int              start;
   int              cand;

   always_comb begin
      lk = '1;
      lk[WAYS-1:0] = lock;
   end

   always_comb begin
      victim  = '0;
      blocked = 1'b1;
      start   = int'(rnd) % WAYS;
      cand    = 0;
      unique case (mode)
         MODE_LRU, MODE_LRR: begin
            for (int i = MAXW - 1; i >= 0; i--) begin
               if (i < WAYS && !lk[order[i]]) begin
                  victim  = order[i];
                  blocked = 1'b0;
               end
            end
         end
         MODE_RAND: begin
            for (int k = MAXW - 1; k >= 0; k--) begin
               if (k < WAYS) begin
                  cand = (start + k) % WAYS;
                  if (!lk[cand]) begin
                     victim  = way_t'(cand);
                     blocked = 1'b0;
                  end
               end
            end
         end
         default: begin
            victim  = dir_way;
            blocked = lk[dir_way];
         end
      endcase
   end

   a_r5_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      !blocked |-> (!lk[victim] && int'(victim) < WAYS));
   a_r6_block_only_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked && mode != MODE_DIRECT) |-> (&lock));
endmodule

// File: rtl/rp_order_update.sv
module rp_order_update
   import rp_pkg::*;
#(
   parameter int WAYS = 4,
   parameter int SW   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [SW-1:0] ld_code,
   input  logic          upd_en,
   input  way_t          upd_way,
   output order_t        base_order,
   output logic [SW-1:0] state_q,
   output logic [SW-1:0] state_nxt
);
   localparam int NPERM = fact(WAYS);

   logic [SW-1:0] base_code;
   logic [SW-1:0] code_q;
   order_t        moved;

   assign base_code  = ld_en ? ld_code : code_q;
   assign base_order = decode_order(code_t'(base_code), WAYS);
   assign moved      = move_to_fresh(base_order, upd_way, WAYS);

   always_comb begin
      if (upd_en) state_nxt = SW'(encode_order(moved, WAYS));
      else        state_nxt = base_code;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= state_nxt;
   end

   assign state_q = code_q;

   order_t q_order;
   assign q_order = decode_order(code_t'(code_q), WAYS);

   a_r3_way_lands_fresh: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (q_order[WAYS-1] == $past(upd_way)));
   a_r11_code_legal_after_update: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (int'(code_q) < NPERM));
endmodule

// File: rtl/perm_lru_sel.sv
module perm_lru_sel
   import rp_pkg::*;
#(
   parameter int          WAYS      = 4,
   parameter int          LFSR_W    = 8,
   parameter logic [7:0]  LFSR_TAPS = 8'hB8,
   localparam int         WW        = (WAYS > 2) ? 2 : 1,
   localparam int         SW        = code_bits(WAYS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_en,
   input  logic [WW-1:0]   acc_way,
   input  logic            fill_req,
   input  logic [1:0]      repl_mode,
   input  logic [WAYS-1:0] way_lock,
   input  logic            ld_en,
   input  logic [SW-1:0]   ld_code,
   output logic [WW-1:0]   victim_way,
   output logic            fill_block,
   output logic [SW-1:0]   state_q,
   output logic [SW-1:0]   state_nxt
);
   if (WAYS < 2 || WAYS > MAXW) begin : g_bad_ways
      $error("perm_lru_sel: WAYS must be 2..4");
   end
   if (LFSR_W != 8) begin : g_bad_lfsr
      $error("perm_lru_sel: LFSR_W must be 8 to match LFSR_TAPS");
   end

   repl_mode_e mode;
   order_t     base_order;
   way_t       acc_w;
   way_t       vic;
   logic       blk;
   logic [LFSR_W-1:0] rnd;
   logic       fill_go;
   logic       acc_go;
   logic       upd_en;
   way_t       upd_way;

   assign mode  = repl_mode_e'(repl_mode);
   assign acc_w = way_t'(acc_way);

   rp_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .value (rnd)
   );

   rp_victim_pick #(.WAYS(WAYS), .LFSR_W(LFSR_W)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .order   (base_order),
      .lock    (way_lock),
      .dir_way (acc_w),
      .rnd     (rnd),
      .victim  (vic),
      .blocked (blk)
   );

   assign fill_go = fill_req && !blk;
   assign acc_go  = acc_en && (mode == MODE_LRU) && (int'(acc_w) < WAYS);
   assign upd_en  = fill_go || acc_go;
   assign upd_way = fill_go ? vic : acc_w;

   rp_order_update #(.WAYS(WAYS), .SW(SW)) u_upd (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_en      (ld_en),
      .ld_code    (ld_code),
      .upd_en     (upd_en),
      .upd_way    (upd_way),
      .base_order (base_order),
      .state_q    (state_q),
      .state_nxt  (state_nxt)
   );

   assign victim_way = WW'(vic);
   assign fill_block = blk;

   a_r7_access_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !fill_req && !ld_en && repl_mode != 2'd0) |=> $stable(state_q));
   a_r6_blocked_fill_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && fill_block && !acc_en && !ld_en) |=> $stable(state_q));
endmodule

// File: tb/perm_lru_sel_bench.sv
`timescale 1ns/1ps
module perm_lru_sel_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_en = 1'b0;
   logic [1:0] acc_way = '0;
   logic       fill_req = 1'b0;
   logic [1:0] repl_mode = '0;
   logic [3:0] way_lock = '0;
   logic       ld_en = 1'b0;
   logic [4:0] ld_code = '0;
   logic [1:0] victim_way;
   logic       fill_block;
   logic [4:0] state_q;
   logic [4:0] state_nxt;

   int checks = 0;
   int failures = 0;
   int ord[4];
   int exp_code = 0;
   bit done = 0;

   always #2 clk = ~clk;

   perm_lru_sel #(.WAYS(4)) u_perm_lru_sel (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_way(acc_way),
      .fill_req(fill_req), .repl_mode(repl_mode), .way_lock(way_lock),
      .ld_en(ld_en), .ld_code(ld_code), .victim_way(victim_way),
      .fill_block(fill_block), .state_q(state_q), .state_nxt(state_nxt)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // index of an order in lexicographic enumeration
   function automatic int rank_of(input int o0, input int o1, input int o2, input int o3);
      int cnt = 0;
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
               for (int d = 0; d < 4; d++)
                  if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                     if (a == o0 && b == o1 && c == o2 && d == o3) return cnt;
                     cnt++;
                  end
      return -1;
   endfunction

   task automatic set_from_code(input int code);
      int cnt = 0;
      ord = '{0, 1, 2, 3};
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
               for (int d = 0; d < 4; d++)
                  if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                     if (cnt == code) ord = '{a, b, c, d};
                     cnt++;
                  end
   endtask

   task automatic to_fresh(input int w);
      int q[$];
      foreach (ord[i]) if (ord[i] != w) q.push_back(ord[i]);
      q.push_back(w);
      foreach (ord[i]) ord[i] = q[i];
   endtask

   task automatic step(input string tag, input bit acc, input int aw, input bit fill,
                       input int md, input logic [3:0] lk, input bit ld = 0, input int lv = 0);
      int  ev;
      bit  eb;
      bit  upd;
      int  uw;
      @(negedge clk);
      acc_en = acc; acc_way = 2'(aw); fill_req = fill; repl_mode = 2'(md);
      way_lock = lk; ld_en = ld; ld_code = 5'(lv);
      #1;
      if (ld) begin set_from_code(lv); exp_code = lv; end
      ev = 0; eb = 1;
      if (md == 3) begin ev = aw; eb = lk[aw]; end
      else begin
         for (int i = 3; i >= 0; i--) if (!lk[ord[i]]) begin ev = ord[i]; eb = 0; end
      end
      chk(fill_block == eb, tag, "fill_block", int'(fill_block), int'(eb));
      if (!eb) begin
         if (md == 2) begin
            chk(!lk[victim_way], tag, "random victim unlocked", int'(victim_way), -1);
            ev = int'(victim_way);
         end else
            chk(int'(victim_way) == ev, tag, "victim_way", int'(victim_way), ev);
      end
      upd = 0; uw = 0;
      if (fill && !eb) begin upd = 1; uw = ev; end
      else if (acc && md == 0) begin upd = 1; uw = aw; end
      if (upd) begin
         to_fresh(uw);
         exp_code = rank_of(ord[0], ord[1], ord[2], ord[3]);
      end
      chk(int'(state_nxt) == exp_code, tag, "state_nxt", int'(state_nxt), exp_code);
      @(posedge clk);
      #1;
      chk(int'(state_q) == exp_code, tag, "state_q", int'(state_q), exp_code);
   endtask

   initial begin
      #(4ns * 200000);
      if (!done) begin
         chk(0, "WATCHDOG", "timeout", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      ord = '{0, 1, 2, 3};
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(state_q == 5'd0, "R1", "reset code", int'(state_q), 0);
      chk(victim_way == 2'd0 && !fill_block, "R1", "reset victim", int'(victim_way), 0);

      // R3 accesses move to fresh end; R2 code values (0123 + way0 -> 1230 = 9)
      step("R3", 1, 0, 0, 0, 4'h0);
      chk(state_q == 5'd9, "R2", "code of 1230", int'(state_q), 9);
      step("R3", 1, 2, 0, 0, 4'h0);
      step("R3", 1, 1, 0, 0, 4'h0);
      // R2: load 0213 (2), access way1 -> 0231 (3)
      step("R2", 1, 1, 0, 0, 4'h0, 1, 2);
      chk(state_q == 5'd3, "R2", "code of 0231", int'(state_q), 3);
      // R5 / R4 fills with locks in recency mode
      step("R5", 0, 0, 1, 0, 4'h1);
      step("R5", 0, 0, 1, 0, 4'h5);
      step("R4", 0, 0, 1, 0, 4'h0);
      // R6 all locked
      step("R6", 0, 0, 1, 0, 4'hF);
      step("R6", 0, 0, 1, 1, 4'hF);
      step("R6", 0, 0, 1, 2, 4'hF);
      // R7 replacement order: accesses ignored, fills reorder
      step("R7", 1, 3, 0, 1, 4'h0);
      step("R7", 1, 0, 0, 1, 4'h0);
      step("R7", 0, 0, 1, 1, 4'h2);
      step("R7", 1, 2, 0, 2, 4'h0);
      step("R7", 1, 1, 0, 3, 4'h0);
      // R8 random mode fills
      for (int i = 0; i < 24; i++) step("R8", 0, 0, 1, 2, 4'(i % 15));
      // R9 direct mode
      step("R9", 0, 2, 1, 3, 4'h0);
      step("R9", 0, 1, 1, 3, 4'h2);
      step("R9", 0, 3, 1, 3, 4'h4);
      // R10 fill and access together
      step("R10", 0, 0, 0, 0, 4'h0, 1, 0);
      step("R10", 1, 3, 1, 0, 4'h0);
      step("R10", 1, 1, 1, 0, 4'h4);
      // R11 illegal codes
      step("R11", 0, 0, 0, 0, 4'h0, 1, 30);
      step("R11", 0, 0, 0, 0, 4'h0);
      step("R11", 1, 2, 0, 0, 4'h0, 1, 27);
      chk(state_q == 5'd1, "R11", "recovered to 0132", int'(state_q), 1);
      step("R11", 0, 0, 1, 0, 4'h0, 1, 31);
      // long random run against the list model
      for (int i = 0; i < 600; i++) begin
         int md = $urandom_range(0, 3);
         step("R3", 1'($urandom), $urandom_range(0, 3), 1'($urandom),
              md, 4'($urandom_range(0, 15) & $urandom_range(0, 15)),
              ($urandom_range(0, 15) == 0), $urandom_range(0, 31));
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule